// File: doc/BRIEF.md
# Variable-Width SPI Shift Engine

This block is the serial core of a single-lane SPI master. It pulls one transmit entry at a time from an external transmit FIFO. Each entry says how many bits to shift, holds those bits left-aligned under the length field, and comes with a flag that decides whether chip select stays low once the entry is done. The engine drives SCLK from a 12-bit programmable divider. It honours a selectable idle polarity and separate choices of launch edge and capture edge. Data moves MSB first in both directions, and each finished word goes to a receive FIFO write port, right-aligned.

Every entry is followed by two idle SCLK periods before the next one starts. Because length and chip-select handling travel with each entry, a driver can chain chunks of different sizes under one chip-select assertion. A busy flag and a live count of the bits still to be captured are exported for status logic. Clearing the enable input lets the current entry, including its idle gap, finish, and then the engine parks with SCLK at its idle level.

Top module: `varspi_engine`

## Requirements
- R1: Within an entry, SCLK changes level exactly every speed+1 clock cycles. The SCLK frequency is therefore clk/(2*(speed+1)), and speed 0 gives half the clock rate.
- R2: Bits 31:24 of an entry give its bit count, and values above 24 are treated as 24. An entry with count c produces exactly c SCLK periods: 2*c edges, c of them rising.
- R3: MOSI presents the entry's payload MSB first. The first bit sent is bit 23 of the entry, followed by bits 22, 21 and so on, for c bits.
- R4: Once the last bit of an entry is captured, rx_push pulses for one cycle. In that cycle rx_data holds the c received bits right-aligned in bits c-1:0, with the first received bit at bit c-1 and zeros above.
- R5: cs_n goes low when a non-empty entry starts. At the end of the entry's last bit, it goes high if the entry's keep flag is 0 and stays low if the flag is 1. After reset cs_n is 1.
- R6: When the next entry is already waiting, its first SCLK edge comes exactly 5*(speed+1)+1 clock cycles after the last edge of the previous entry. This is two idle SCLK periods plus one boundary cycle plus one half period.
- R7: While no entry is active, SCLK rests at the level given by cpol. Every entry begins and ends with SCLK at that level.
- R8: MOSI changes only on SCLK edges whose direction matches out_rising (1 = rising). The first edge of an entry never moves MOSI. MISO is sampled on the edges whose direction matches in_rising.
- R9: busy is 1 from the cycle after a non-empty entry is taken until its idle gap ends. bit_cnt equals c when the entry starts, drops by one at each capture edge, and is 0 when rx_push fires. After reset, busy and bit_cnt are 0.
- R10: An entry with count 0 is removed from the FIFO without any SCLK edge, without rx_push and without any change on cs_n.
- R11: When enable is 0, no new entry is taken. An entry already started still completes, and SCLK then rests at its idle level.
- R12: tx_pop is 1 only in a cycle where the engine is idle, enable is 1 and tx_valid is 1. The entry on tx_data is consumed at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Permit taking new entries |
| speed | input | 12 | Divider setting; half period is speed+1 cycles |
| cpol | input | 1 | Idle level of SCLK |
| out_rising | input | 1 | 1: MOSI launched on rising edges, 0: on falling |
| in_rising | input | 1 | 1: MISO sampled on rising edges, 0: on falling |
| tx_valid | input | 1 | Transmit FIFO holds an entry |
| tx_data | input | 32 | Entry: count in 31:24, payload left-aligned in 23:0 |
| tx_keep_cs | input | 1 | Keep chip select low after this entry |
| tx_pop | output | 1 | Read strobe to the transmit FIFO |
| rx_push | output | 1 | Write strobe to the receive FIFO |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Entry or idle gap in progress |
| bit_cnt | output | 5 | Bits still to be captured in the current entry |

## Verification
The bench uses the default parameters: a 12-bit divider, an 8-bit count field and 24-bit payloads with a four-half-period gap. This lets it run full-width entries and entries longer than 24 bits, which must be clamped. It programs speed values 0, 1, 2 and 5. These settings make the exact half-period spacing and the back-to-back gap measurable, and keep the runs short. It runs three edge configurations with MISO looped back to MOSI, and two with MISO held constant. This separates transmit order from receive alignment. Zero-length entries and an enable drop in the middle of a stream are exercised at the FIFO side and on the pins.

// File: rtl/varspi_pkg.sv
package varspi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_e;

    // Edge configuration captured when an entry is taken.
    typedef struct packed {
        logic cpol;
        logic launch_rise;
        logic sample_rise;
    } edge_cfg_t;

endpackage

// File: rtl/varspi_clkdiv.sv
// Half-period tick generator: tick every limit+1 cycles while run is high.
module varspi_clkdiv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/varspi_len_clamp.sv
// Turns the raw length field into a bit count no larger than the payload.
module varspi_len_clamp #(
    parameter int LEN_W    = 8,
    parameter int MAX_BITS = 24,
    parameter int BC_W     = 5
) (
    input  logic [LEN_W-1:0] raw_len,
    output logic [BC_W-1:0]  bits,
    output logic             empty
);

    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_BITS);

    always_comb begin
        if (raw_len > LIMIT) begin
            bits = BC_W'(MAX_BITS);
        end else begin
            bits = BC_W'(raw_len);
        end
        empty = (raw_len == '0);
    end

endmodule

// File: rtl/varspi_shifter.sv
// Transmit and receive shift registers, MSB first.
module varspi_shifter #(
    parameter int MAX_BITS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] load_bits,
    input  logic                adv,
    input  logic                cap,
    input  logic                miso,
    output logic                mosi,
    output logic [MAX_BITS-1:0] rx_word
);

    typedef struct packed {
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx;
    } shreg_t;

    shreg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx = load_bits;
            sh_d.rx = '0;
        end else begin
            if (adv) begin
                sh_d.tx = {sh_q.tx[MAX_BITS-2:0], 1'b0};
            end
            if (cap) begin
                sh_d.rx = {sh_q.rx[MAX_BITS-2:0], miso};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi    = sh_q.tx[MAX_BITS-1];
    assign rx_word = sh_q.rx;

endmodule

// File: rtl/varspi_engine.sv
module varspi_engine
    import varspi_pkg::*;
#(
    parameter int  DIV_W      = 12,
    parameter int  ENTRY_W    = 32,
    parameter int  LEN_W      = 8,
    parameter int  GAP_HALVES = 4,
    localparam int MAX_BITS   = ENTRY_W - LEN_W,
    localparam int BC_W       = $clog2(MAX_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   speed,
    input  logic               cpol,
    input  logic               out_rising,
    input  logic               in_rising,
    input  logic               tx_valid,
    input  logic [ENTRY_W-1:0] tx_data,
    input  logic               tx_keep_cs,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [ENTRY_W-1:0] rx_data,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic               cs_n,
    output logic               busy,
    output logic [BC_W-1:0]    bit_cnt
);

    localparam int EDGE_W = $clog2(2 * MAX_BITS + 1);
    localparam int GAP_W  = $clog2(GAP_HALVES + 1);

    typedef struct packed {
        eng_state_e        state;
        logic              sclk;
        logic              cs_n;
        logic              hold;
        logic              first;
        logic              push;
        logic [EDGE_W-1:0] edges;
        logic [BC_W-1:0]   bits;
        logic [GAP_W-1:0]  gap;
        edge_cfg_t         cfg;
        logic [DIV_W-1:0]  div;
    } ctrl_t;

    ctrl_t q, n;

    logic              tick;
    logic [BC_W-1:0]   ent_bits;
    logic              ent_empty;
    logic              ld, adv, cap, rise;
    logic [MAX_BITS-1:0] rx_word;

    varspi_len_clamp #(
        .LEN_W    (LEN_W),
        .MAX_BITS (MAX_BITS),
        .BC_W     (BC_W)
    ) i_clamp (
        .raw_len (tx_data[ENTRY_W-1 -: LEN_W]),
        .bits    (ent_bits),
        .empty   (ent_empty)
    );

    varspi_clkdiv #(
        .DIV_W (DIV_W)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.state != ST_IDLE),
        .limit (q.div),
        .tick  (tick)
    );

    varspi_shifter #(
        .MAX_BITS (MAX_BITS)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_bits (tx_data[MAX_BITS-1:0]),
        .adv       (adv),
        .cap       (cap),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    always_comb begin
        n      = q;
        n.push = 1'b0;
        ld     = 1'b0;
        adv    = 1'b0;
        cap    = 1'b0;
        rise   = 1'b0;
        tx_pop = (q.state == ST_IDLE) && enable && tx_valid;

        unique case (q.state)
            ST_IDLE: begin
                n.sclk = cpol;
                if (tx_pop && !ent_empty) begin
                    ld        = 1'b1;
                    n.state   = ST_SHIFT;
                    n.cs_n    = 1'b0;
                    n.hold    = tx_keep_cs;
                    n.first   = 1'b1;
                    n.edges   = EDGE_W'({ent_bits, 1'b0});
                    n.bits    = ent_bits;
                    n.cfg     = '{cpol: cpol, launch_rise: out_rising,
                                  sample_rise: in_rising};
                    n.div     = speed;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    rise    = ~q.sclk;
                    n.sclk  = rise;
                    cap     = (rise == q.cfg.sample_rise);
                    adv     = (rise == q.cfg.launch_rise) && !q.first;
                    n.first = 1'b0;
                    if (cap) begin
                        n.bits = q.bits - BC_W'(1);
                    end
                    n.edges = q.edges - EDGE_W'(1);
                    if (q.edges == EDGE_W'(1)) begin
                        n.state = ST_GAP;
                        n.gap   = GAP_W'(GAP_HALVES);
                        n.push  = 1'b1;
                        n.cs_n  = ~q.hold;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap == GAP_W'(1)) begin
                        n.state = ST_IDLE;
                    end else begin
                        n.gap = q.gap - GAP_W'(1);
                    end
                end
            end
            default: begin
                n.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign rx_push = q.push;
    assign rx_data = ENTRY_W'(rx_word);
    assign sclk    = q.sclk;
    assign cs_n    = q.cs_n;
    assign busy    = (q.state != ST_IDLE);
    assign bit_cnt = q.bits;

endmodule

// File: rtl/varspi_checks.sv
module varspi_checks #(
    parameter int MAX_BITS = 24,
    parameter int BC_W     = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            cpol,
    input logic            tx_valid,
    input logic            tx_pop,
    input logic            rx_push,
    input logic            sclk,
    input logic            cs_n,
    input logic            busy,
    input logic [BC_W-1:0] bit_cnt
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assert_pop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (!busy && enable && tx_valid));

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BC_W'(MAX_BITS));

    assert_push_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> busy);

    assert_push_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !busy && !$past(busy)) |-> (sclk == $past(cpol)));

    assert_edge_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && busy && $past(busy) && !$stable(sclk)) |-> !$past(cs_n));

    assert_release_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(cs_n)) |-> rx_push);

endmodule

bind varspi_engine varspi_checks #(
    .MAX_BITS (MAX_BITS),
    .BC_W     (BC_W)
) i_varspi_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cpol     (cpol),
    .tx_valid (tx_valid),
    .tx_pop   (tx_pop),
    .rx_push  (rx_push),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .busy     (busy),
    .bit_cnt  (bit_cnt)
);

// File: tb/test_varspi_engine.sv
module test_varspi_engine;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          bits;
        logic [23:0] exp_tx;
        logic [23:0] exp_rx;
        logic        hold;
        logic        chk_gap;
        int          spd;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [11:0] speed = '0;
    logic        cpol = 1'b0;
    logic        out_rising = 1'b0;
    logic        in_rising = 1'b1;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_keep_cs;
    logic        tx_pop;
    logic        rx_push;
    logic [31:0] rx_data;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic        cs_n;
    logic        busy;
    logic [4:0]  bit_cnt;

    logic        loop_mode = 1'b1;
    logic        miso_level = 1'b0;

    logic [32:0] fifo_mem [0:63];
    int          wr_ptr = 0;
    int          rd_ptr = 0;
    logic        pop_seen = 1'b0;

    item_t       sb[$];
    int          n_checks = 0;
    int          n_errors = 0;
    int          n_pushes = 0;
    int          n_edges = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign tx_valid   = (wr_ptr != rd_ptr);
    assign tx_data    = fifo_mem[rd_ptr % 64][31:0];
    assign tx_keep_cs = fifo_mem[rd_ptr % 64][32];
    assign miso       = loop_mode ? mosi : miso_level;

    varspi_engine i_varspi_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .speed      (speed),
        .cpol       (cpol),
        .out_rising (out_rising),
        .in_rising  (in_rising),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_keep_cs (tx_keep_cs),
        .tx_pop     (tx_pop),
        .rx_push    (rx_push),
        .rx_data    (rx_data),
        .sclk       (sclk),
        .mosi       (mosi),
        .miso       (miso),
        .cs_n       (cs_n),
        .busy       (busy),
        .bit_cnt    (bit_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_entry(input int len_raw, input logic [23:0] data,
                              input logic hold, input logic chk_gap);
        item_t it;
        int    c;
        fifo_mem[wr_ptr % 64] = {hold, 8'(len_raw), data};
        wr_ptr++;
        c = (len_raw > 24) ? 24 : len_raw;
        if (c > 0) begin
            it.bits    = c;
            it.exp_tx  = data >> (24 - c);
            it.exp_rx  = loop_mode ? it.exp_tx
                                   : (miso_level ? 24'((32'd1 << c) - 1) : 24'd0);
            it.hold    = hold;
            it.chk_gap = chk_gap;
            it.spd     = int'(speed);
            sb.push_back(it);
        end
    endtask

    task automatic set_mode(input logic p, input logic orise, input logic irise,
                            input int spd, input logic loop, input logic lvl);
        cpol       = p;
        out_rising = orise;
        in_rising  = irise;
        speed      = 12'(spd);
        loop_mode  = loop;
        miso_level = lvl;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0 || busy || wr_ptr != rd_ptr) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // transmit FIFO model: an entry taken at a posedge leaves at the next negedge
    always @(negedge clk) begin
        if (pop_seen) rd_ptr++;
        #1 pop_seen = tx_pop;
    end

    // monitor and scoreboard
    logic        p_sclk = 1'b0, p_mosi = 1'b0, p_busy = 1'b0;
    int          cyc = 0, last_edge = 0;
    int          ent_edges = 0, ent_rise = 0, hp_err = 0, launch_err = 0;
    logic [23:0] mosi_bits = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && !p_busy) begin
                ent_edges = 0; ent_rise = 0; hp_err = 0; launch_err = 0;
                mosi_bits = '0;
                if (sb.size() != 0) begin
                    chk(bit_cnt == 5'(sb[0].bits), "R9", "bit_cnt at start",
                        bit_cnt, sb[0].bits);
                    chk(cs_n == 1'b0, "R5", "cs_n low at start", cs_n, 0);
                end
            end
            if (sclk != p_sclk && busy && p_busy) begin
                n_edges++;
                if (sb.size() != 0) begin
                    if (ent_edges == 0 && sb[0].chk_gap)
                        chk(cyc - last_edge == 5 * (sb[0].spd + 1) + 1, "R6",
                            "gap to next entry", cyc - last_edge,
                            5 * (sb[0].spd + 1) + 1);
                    if (ent_edges > 0 && cyc - last_edge != sb[0].spd + 1)
                        hp_err++;
                end
                ent_edges++;
                if (sclk) ent_rise++;
                if (sclk == in_rising) mosi_bits = {mosi_bits[22:0], mosi};
                last_edge = cyc;
            end
            if (mosi != p_mosi && busy && p_busy) begin
                if (!(sclk != p_sclk && sclk == out_rising)) launch_err++;
            end
            if (rx_push) begin
                n_pushes++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R4", "unexpected rx_push", rx_data, 0);
                end else begin
                    item_t it;
                    logic [23:0] msk;
                    it  = sb.pop_front();
                    msk = 24'((32'd1 << it.bits) - 1);
                    chk(rx_data == {8'h00, it.exp_rx}, "R4", "rx_data",
                        rx_data, it.exp_rx);
                    chk((mosi_bits & msk) == it.exp_tx, "R3", "mosi bit order",
                        mosi_bits & msk, it.exp_tx);
                    chk(ent_edges == 2 * it.bits && ent_rise == it.bits, "R2",
                        "sclk edges", ent_edges, 2 * it.bits);
                    chk(hp_err == 0, "R1", "half-period spacing", hp_err, 0);
                    chk(launch_err == 0, "R8", "mosi launch edge", launch_err, 0);
                    chk(sclk == cpol, "R7", "sclk level at end", sclk, cpol);
                    chk(cs_n == !it.hold, "R5", "cs_n after entry", cs_n, !it.hold);
                    chk(bit_cnt == 5'd0, "R9", "bit_cnt at end", bit_cnt, 0);
                end
            end
        end
        p_sclk = sclk;
        p_mosi = mosi;
        p_busy = busy;
    end

    initial begin
        int pushes0, edges0;
        logic cs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R5", "reset cs_n", cs_n, 1);
        chk(busy == 1'b0 && bit_cnt == 5'd0, "R9", "reset busy/bit_cnt",
            {busy, bit_cnt}, 0);
        chk(rx_push == 1'b0, "R4", "reset rx_push", rx_push, 0);
        chk(sclk == 1'b0, "R7", "reset sclk", sclk, 0);
        chk(tx_pop == 1'b0, "R12", "pop while disabled", tx_pop, 0);

        // capture rising, launch falling, idle low, fastest clock
        set_mode(1'b0, 1'b0, 1'b1, 0, 1'b1, 1'b0);
        push_entry(8, 24'hA50000, 1'b1, 1'b0);
        push_entry(24, 24'h123456, 1'b1, 1'b1);
        push_entry(1, 24'h800000, 1'b1, 1'b1);
        push_entry(13, 24'h5A5A5A, 1'b0, 1'b1);
        enable = 1'b1;
        drain();
        chk(sclk == 1'b0, "R7", "idle low after stream", sclk, 0);
        chk(cs_n == 1'b1, "R5", "cs released after stream", cs_n, 1);

        // idle high, capture falling, launch rising
        set_mode(1'b1, 1'b1, 1'b0, 2, 1'b1, 1'b0);
        chk(sclk == 1'b1, "R7", "idle level follows cpol", sclk, 1);
        push_entry(16, 24'hC3A500, 1'b0, 1'b0);
        push_entry(5, 24'hF80000, 1'b1, 1'b1);
        push_entry(24, 24'h9ABCDE, 1'b0, 1'b1);
        drain();

        // idle low, launch on leading edge, capture trailing; length clamp
        set_mode(1'b0, 1'b1, 1'b0, 5, 1'b1, 1'b0);
        push_entry(40, 24'h00F0F1, 1'b0, 1'b0);
        push_entry(7, 24'hDE0000, 1'b0, 1'b1);
        drain();

        // constant MISO: alignment with zeros above the word
        set_mode(1'b0, 1'b0, 1'b1, 1, 1'b0, 1'b1);
        push_entry(10, 24'h3FF000, 1'b0, 1'b0);
        drain();
        set_mode(1'b0, 1'b0, 1'b1, 1, 1'b0, 1'b0);
        push_entry(12, 24'hFFF000, 1'b0, 1'b0);
        drain();

        // R10: zero-length entry with keep flag set
        pushes0 = n_pushes; edges0 = n_edges; cs0 = cs_n;
        push_entry(0, 24'hFFFFFF, 1'b1, 1'b0);
        repeat (30) @(negedge clk);
        chk(wr_ptr == rd_ptr, "R10", "zero entry consumed", wr_ptr - rd_ptr, 0);
        chk(n_edges == edges0, "R10", "no sclk edges", n_edges - edges0, 0);
        chk(n_pushes == pushes0, "R10", "no rx_push", n_pushes - pushes0, 0);
        chk(cs_n == cs0 && busy == 1'b0, "R10", "cs_n unchanged", cs_n, cs0);

        // R11: drop enable during an entry
        set_mode(1'b0, 1'b0, 1'b1, 3, 1'b1, 1'b0);
        enable = 1'b0;
        pushes0 = n_pushes;
        push_entry(12, 24'hABC000, 1'b0, 1'b0);
        push_entry(12, 24'h135000, 1'b0, 1'b0);
        @(negedge clk);
        chk(tx_pop == 1'b0 && wr_ptr - rd_ptr == 2, "R12", "no pop while disabled",
            wr_ptr - rd_ptr, 2);
        enable = 1'b1;
        while (!busy) @(negedge clk);
        enable = 1'b0;
        repeat (200) @(negedge clk);
        chk(n_pushes - pushes0 == 1, "R11", "current entry finished",
            n_pushes - pushes0, 1);
        chk(wr_ptr - rd_ptr == 1, "R11", "next entry left in fifo",
            wr_ptr - rd_ptr, 1);
        chk(busy == 1'b0 && sclk == cpol, "R11", "parked at idle level", sclk, cpol);
        enable = 1'b1;
        drain();
        chk(n_pushes - pushes0 == 2, "R11", "resumes after enable",
            n_pushes - pushes0, 2);
        chk(sb.size() == 0, "R4", "all entries answered", sb.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule